// File: doc/BRIEF.md
# Endpoint Queue Head Priming Engine

This block maintains the per-endpoint queue heads of a USB device controller. All queue heads live in one flat array in system memory. The engine picks an entry straight from the endpoint number and direction, with no list walk. On a prime request it records the transfer descriptor address in the queue head. It then copies the descriptor's leading words into the queue head's overlay (staging) area. On a completion request it fetches the current-descriptor pointer from the queue head and writes the status word into that descriptor.

The engine works one request at a time through a valid/ready handshake and signals the end of each request with a one-cycle done pulse. All memory traffic goes through a single word-wide master port. Each access is held until the memory returns a single-cycle acknowledge.

Queue head layout in its 64-byte slot: +0 endpoint capabilities (static), +4 current-descriptor pointer, +8 to +32 overlay (next pointer, token/status, five buffer pointers). In a descriptor, the token/status word sits at +4.

Top module: `qh_prime_engine`

## Requirements
- R1: `req_ready_o` is high exactly when the engine is idle, and no memory request is issued while it is high. A request presented while ready is low is ignored and causes no memory access and no done pulse.
- R2: The queue head address is (`list_base_i` with bits [10:0] cleared) + 64 × (2 × ep + dir). dir = 0 selects the OUT/SETUP entry and dir = 1 the IN entry. The first access of every accepted request targets this address + 4.
- R3: An endpoint number at or above `NUM_EP` (default 12) ends the request with `done_o` and `err_o` high for one cycle, one cycle after acceptance, and makes no memory access.
- R4: A prime request (`req_op_i` = 0) starts with a write of `req_data_i` (the descriptor address) to queue head + 4.
- R5: A prime then makes 7 read/write pairs for k = 0..6 in ascending order. Each pair reads descriptor + 4k and writes the returned word to queue head + 8 + 4k. A prime makes 15 accesses in total.
- R6: A completion request (`req_op_i` = 1) reads queue head + 4 and writes `req_data_i` to (the returned pointer) + 4. It makes exactly 2 accesses.
- R7: Neither operation ever writes the capabilities word at queue head + 0.
- R8: While `mem_req_o` is high and `mem_ack_i` is low, the next cycle keeps `mem_req_o` high with `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged.
- R9: A valid request ends with a one-cycle `done_o` pulse with `err_o` low, in the cycle after its last acknowledge, and `req_ready_o` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| list_base_i | input | 32 | Queue head array base address |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_op_i | input | 1 | 0 = prime, 1 = completion |
| req_ep_i | input | 4 | Endpoint number |
| req_dir_i | input | 1 | 0 = OUT/SETUP, 1 = IN |
| req_data_i | input | 32 | Descriptor address (prime) or status word (completion) |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Endpoint out of range, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Single-cycle access acknowledge |

## Verification
The bench uses a list base with junk in its low 11 bits. A design that kept those bits would place every queue head off its slot, so the first write lands at the wrong address. It drives endpoints 12 to 15 to catch a range check that is off by one or missing; such a design would touch memory or raise no error. It sends requests while the engine is busy; a design that accepts them would corrupt the running copy or add accesses. The memory model acknowledges after a random delay, so a design that drops its request or shifts the overlay word index before the acknowledge ends up with the wrong overlay contents. Completion checks compare the status word in the descriptor named by the queue head's pointer against the queue head's own words. This catches a design that writes status into the queue head or clobbers the capabilities word.

// File: rtl/qh_pkg.sv
package qh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_CUR,
    ST_RD_DTD,
    ST_WR_OVL,
    ST_RD_CUR,
    ST_WR_STS
  } qh_state_e;

  localparam int unsigned QH_CUR_OFS  = 4;
  localparam int unsigned QH_OVL_OFS  = 8;
  localparam int unsigned DTD_STS_OFS = 4;
endpackage

// File: rtl/qh_addr_gen.sv
module qh_addr_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned EP_W       = 4,
  parameter int unsigned NUM_EP     = 12,
  parameter int unsigned SLOT_LOG2  = 6,
  parameter int unsigned ALIGN_LOG2 = 11
) (
  input  logic [AW-1:0]   base_i,
  input  logic [EP_W-1:0] ep_i,
  input  logic            dir_i,
  output logic [AW-1:0]   slot_o,
  output logic            ep_ok_o
);
  localparam int unsigned IDX_W      = EP_W + 1;
  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << ALIGN_LOG2) - AW'(1));

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    ofs;

  always_comb begin
    idx     = {ep_i, dir_i};
    ofs     = AW'(idx) << SLOT_LOG2;
    slot_o  = (base_i & BASE_MASK) | ofs;
    ep_ok_o = 32'(ep_i) < NUM_EP;
  end
endmodule

// File: rtl/qh_ctx_regs.sv
module qh_ctx_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] slot_i,
  input  logic [AW-1:0] data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rdata_i,
  output logic [AW-1:0] slot_q_o,
  output logic [AW-1:0] data_q_o,
  output logic [AW-1:0] rd_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q_o <= '0;
      data_q_o <= '0;
    end else if (capture_i) begin
      slot_q_o <= slot_i;
      data_q_o <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q_o <= '0;
    else if (rd_en_i) rd_q_o <= rdata_i;
  end
endmodule

// File: rtl/qh_seq.sv
module qh_seq
  import qh_pkg::*;
#(
  parameter int unsigned OVL_WORDS = 7,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_op_i,
  input  logic             ep_ok_i,
  input  logic             mem_ack_i,
  output qh_state_e        state_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             capture_o,
  output logic             rd_en_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OVL_WORDS - 1);

  qh_state_e        state_d;
  logic [CNT_W-1:0] idx_d;
  logic             done_d, err_d;

  assign ready_o   = (state_o == ST_IDLE);
  assign capture_o = ready_o && req_valid_i && ep_ok_i;
  assign rd_en_o   = mem_ack_i && (state_o == ST_RD_DTD || state_o == ST_RD_CUR);

  always_comb begin
    state_d = state_o;
    idx_d   = idx_o;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_o)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (!ep_ok_i) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            idx_d   = '0;
            state_d = req_op_i ? ST_RD_CUR : ST_WR_CUR;
          end
        end
      end
      ST_WR_CUR: if (mem_ack_i) state_d = ST_RD_DTD;
      ST_RD_DTD: if (mem_ack_i) state_d = ST_WR_OVL;
      ST_WR_OVL: begin
        if (mem_ack_i) begin
          if (idx_o == LAST_IDX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d   = idx_o + CNT_W'(1);
            state_d = ST_RD_DTD;
          end
        end
      end
      ST_RD_CUR: if (mem_ack_i) state_d = ST_WR_STS;
      ST_WR_STS: begin
        if (mem_ack_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      idx_o   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_o <= state_d;
      idx_o   <= idx_d;
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/qh_prime_engine.sv
module qh_prime_engine
  import qh_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned EP_W      = 4,
  parameter int unsigned NUM_EP    = 12,
  parameter int unsigned OVL_WORDS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   list_base_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_op_i,
  input  logic [EP_W-1:0] req_ep_i,
  input  logic            req_dir_i,
  input  logic [AW-1:0]   req_data_i,
  output logic            done_o,
  output logic            err_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [AW-1:0]   mem_wdata_o,
  input  logic [AW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i
);
  localparam int unsigned CNT_W = (OVL_WORDS > 2) ? $clog2(OVL_WORDS) : 1;

  qh_state_e        state;
  logic [CNT_W-1:0] idx;
  logic [AW-1:0]    slot_addr, slot_q, data_q, rd_q, word_ofs;
  logic             ep_ok, capture, rd_en;

  qh_addr_gen #(
    .AW(AW), .EP_W(EP_W), .NUM_EP(NUM_EP), .SLOT_LOG2(6), .ALIGN_LOG2(11)
  ) i_addr_gen (
    .base_i (list_base_i),
    .ep_i   (req_ep_i),
    .dir_i  (req_dir_i),
    .slot_o (slot_addr),
    .ep_ok_o(ep_ok)
  );

  qh_seq #(
    .OVL_WORDS(OVL_WORDS), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (req_op_i),
    .ep_ok_i    (ep_ok),
    .mem_ack_i  (mem_ack_i),
    .state_o    (state),
    .idx_o      (idx),
    .capture_o  (capture),
    .rd_en_o    (rd_en),
    .ready_o    (req_ready_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  qh_ctx_regs #(.AW(AW)) i_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .slot_i   (slot_addr),
    .data_i   (req_data_i),
    .rd_en_i  (rd_en),
    .rdata_i  (mem_rdata_i),
    .slot_q_o (slot_q),
    .data_q_o (data_q),
    .rd_q_o   (rd_q)
  );

  assign word_ofs  = AW'(idx) << 2;
  assign mem_req_o = (state != ST_IDLE);

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_WR_CUR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_q + AW'(QH_CUR_OFS);
        mem_wdata_o = data_q;
      end
      ST_RD_DTD: mem_addr_o = data_q + word_ofs;
      ST_WR_OVL: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_q + AW'(QH_OVL_OFS) + word_ofs;
        mem_wdata_o = rd_q;
      end
      ST_RD_CUR: mem_addr_o = slot_q + AW'(QH_CUR_OFS);
      ST_WR_STS: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = rd_q + AW'(DTD_STS_OFS);
        mem_wdata_o = data_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qh_prime_engine_chk.sv
module qh_prime_engine_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned EP_W   = 4,
  parameter int unsigned NUM_EP = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   list_base_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            req_op_i,
  input logic [EP_W-1:0] req_ep_i,
  input logic            req_dir_i,
  input logic [AW-1:0]   req_data_i,
  input logic            done_o,
  input logic            err_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [AW-1:0]   mem_wdata_o,
  input logic [AW-1:0]   mem_rdata_i,
  input logic            mem_ack_i
);
  logic          accept, in_range;
  logic [AW-1:0] exp_slot, slot_lat, data_lat, rd_lat;
  logic          prime_busy, cmpl_busy;

  assign accept   = req_valid_i && req_ready_o;
  assign in_range = (32'(req_ep_i) < NUM_EP);
  assign exp_slot = {list_base_i[AW-1:11], 11'd0} + AW'((2 * 32'(req_ep_i) + 32'(req_dir_i)) * 64);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_lat   <= '0;
      data_lat   <= '0;
      rd_lat     <= '0;
      prime_busy <= 1'b0;
      cmpl_busy  <= 1'b0;
    end else begin
      if (accept && in_range) begin
        slot_lat   <= exp_slot;
        data_lat   <= req_data_i;
        prime_busy <= !req_op_i;
        cmpl_busy  <= req_op_i;
      end else if (done_o) begin
        prime_busy <= 1'b0;
        cmpl_busy  <= 1'b0;
      end
      if (mem_req_o && !mem_we_o && mem_ack_i) rd_lat <= mem_rdata_i;
    end
  end

  assert_idle_no_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);

  assert_first_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range) |=> (mem_req_o && mem_addr_o == slot_lat + 32'd4));

  assert_bad_ep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range) |=> (done_o && err_o && !mem_req_o));

  assert_prime_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range && !req_op_i) |=> (mem_we_o && mem_wdata_o == $past(req_data_i)));

  assert_overlay_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prime_busy && mem_req_o && mem_we_o && mem_addr_o != slot_lat + 32'd4) |-> (mem_wdata_o == rd_lat));

  assert_status_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_busy && mem_req_o && mem_we_o) |-> (mem_addr_o == rd_lat + 32'd4 && mem_wdata_o == data_lat));

  assert_no_cap_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prime_busy && mem_req_o && mem_we_o) |-> (mem_addr_o != slot_lat));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_done_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

bind qh_prime_engine qh_prime_engine_chk #(
  .AW(AW), .EP_W(EP_W), .NUM_EP(NUM_EP)
) i_chk (.*);

// File: tb/test_qh_prime_engine.sv
`timescale 1ns/1ps
module test_qh_prime_engine;
  localparam int NUM_EP = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] list_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_op_i = 1'b0;
  logic [3:0]  req_ep_i = '0;
  logic        req_dir_i = 1'b0;
  logic [31:0] req_data_i = '0;
  logic        done_o, err_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;

  qh_prime_engine #(.NUM_EP(NUM_EP)) i_qh_prime_engine (.*);

  always #2.5 clk_i = ~clk_i;

  logic [31:0] mem_m [0:2047];
  int checks = 0, failures = 0, acc_cnt = 0, cycles = 0;
  logic [31:0] first_addr, first_wdata;
  logic        first_we;
  bit          finished = 0;
  bit          primed [0:31];

  function automatic int widx(input logic [31:0] a);
    return int'(a[12:2]);
  endfunction

  function automatic logic [31:0] exp_slot(input logic [31:0] b, input int ep, input int dir);
    return (b & 32'hFFFF_F800) + 32'((2 * ep + dir) * 64);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: random-latency single-cycle acknowledge
  always @(negedge clk_i) begin
    cycles++;
    if (!rst_ni) mem_ack_i = 1'b0;
    else if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o && ($urandom % 3 != 0)) begin
      if (acc_cnt == 0) begin
        first_addr = mem_addr_o; first_we = mem_we_o; first_wdata = mem_wdata_o;
      end
      acc_cnt++;
      if (mem_we_o) mem_m[widx(mem_addr_o)] = mem_wdata_o;
      else mem_rdata_i = mem_m[widx(mem_addr_o)];
      mem_ack_i = 1'b1;
    end
  end

  task automatic run_op(input bit op, input int ep, input bit dir, input logic [31:0] data, output bit err);
    bit first = 1;
    while (!req_ready_o) @(negedge clk_i);
    acc_cnt = 0;
    req_valid_i = 1'b1; req_op_i = op; req_ep_i = 4'(ep); req_dir_i = dir; req_data_i = data;
    do begin
      @(negedge clk_i);
      if (first) begin req_valid_i = 1'b0; first = 0; end
    end while (!done_o);
    err = err_o;
    chk(req_ready_o === 1'b1, "R9 ready with done", 32'(req_ready_o), 1);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R9 done single cycle", 32'(done_o), 0);
  endtask

  task automatic do_prime(input int ep, input bit dir, input logic [31:0] dtd);
    logic [31:0] s, cap;
    bit err, ok;
    s = exp_slot(list_base_i, ep, dir);
    cap = mem_m[widx(s)];
    run_op(1'b0, ep, dir, dtd, err);
    chk(!err, "R9 no error", 32'(err), 0);
    chk(acc_cnt == 15, "R5 access count", 32'(acc_cnt), 15);
    chk(first_we && first_addr == s + 4 && first_wdata == dtd, "R2 R4 first access", first_addr, s + 4);
    chk(mem_m[widx(s + 4)] == dtd, "R4 cur pointer", mem_m[widx(s + 4)], dtd);
    ok = 1;
    for (int k = 0; k < 7; k++)
      if (mem_m[widx(s + 8 + 4 * k)] != mem_m[widx(dtd + 4 * k)]) ok = 0;
    chk(ok, "R5 overlay copy", mem_m[widx(s + 8)], mem_m[widx(dtd)]);
    chk(mem_m[widx(s)] == cap, "R7 caps untouched", mem_m[widx(s)], cap);
    primed[2 * ep + dir] = 1;
  endtask

  task automatic do_cmpl(input int ep, input bit dir, input logic [31:0] sts);
    logic [31:0] s, cur, cap;
    bit err;
    s = exp_slot(list_base_i, ep, dir);
    cur = mem_m[widx(s + 4)];
    cap = mem_m[widx(s)];
    run_op(1'b1, ep, dir, sts, err);
    chk(!err && acc_cnt == 2, "R6 two accesses", 32'(acc_cnt), 2);
    chk(mem_m[widx(cur + 4)] == sts, "R6 status in descriptor", mem_m[widx(cur + 4)], sts);
    chk(mem_m[widx(s + 4)] == cur && mem_m[widx(s)] == cap, "R6 R7 queue head intact", mem_m[widx(s + 4)], cur);
  endtask

  function automatic logic [31:0] rand_dtd();
    return 32'h1000 + 32'(($urandom % 120) * 32);
  endfunction

  initial begin
    int wd = 0;
    while (wd < 150000 && !finished) begin @(posedge clk_i); wd++; end
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit err;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 2048; i++) mem_m[i] = 32'hC0DE_0000 ^ 32'(i * 32'h9E37);
    for (int i = 0; i < 32; i++) primed[i] = 0;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        {29'd0, req_ready_o, mem_req_o, done_o}, 32'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // misaligned base: low bits must be dropped
    list_base_i = 32'h0000_03A4;
    do_prime(0, 1'b0, 32'h1000);
    do_prime(NUM_EP - 1, 1'b1, 32'h1FC0);
    do_cmpl(0, 1'b0, 32'h8000_00AA);

    // out-of-range endpoints
    for (int ep = NUM_EP; ep < 16; ep++) begin
      run_op(ep[0], ep, ep[1], 32'hDEAD_BEEF, err);
      chk(err == 1'b1, "R3 error flag", 32'(err), 1);
      chk(acc_cnt == 0, "R3 no memory access", 32'(acc_cnt), 0);
    end

    // request while busy is ignored
    begin
      logic [31:0] s;
      s = exp_slot(list_base_i, 3, 1);
      acc_cnt = 0;
      req_valid_i = 1'b1; req_op_i = 1'b0; req_ep_i = 4'd3; req_dir_i = 1'b1; req_data_i = 32'h1100;
      @(negedge clk_i);
      req_op_i = 1'b1; req_ep_i = 4'd5; req_data_i = 32'h0BAD_0BAD;
      repeat (3) begin
        @(negedge clk_i);
        chk(req_ready_o === 1'b0, "R1 busy not ready", 32'(req_ready_o), 0);
      end
      req_valid_i = 1'b0;
      while (!done_o) @(negedge clk_i);
      repeat (6) @(negedge clk_i);
      chk(acc_cnt == 15, "R1 busy request ignored", 32'(acc_cnt), 15);
      chk(mem_m[widx(s + 4)] == 32'h1100, "R1 running prime intact", mem_m[widx(s + 4)], 32'h1100);
      primed[7] = 1;
    end

    // random mix, base in upper window
    list_base_i = 32'h0000_0800 | ($urandom & 32'h7FF);
    for (int i = 0; i < 32; i++) primed[i] = 0;
    for (int n = 0; n < 40; n++) begin
      int ep = int'($urandom % NUM_EP);
      bit dir = 1'($urandom);
      if (primed[2 * ep + 32'(dir)] && ($urandom % 2 == 0)) do_cmpl(ep, dir, $urandom);
      else do_prime(ep, dir, rand_dtd());
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule